// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Acceptance Controller

This block takes sixteen edge-triggered interrupt request lines, remembers each rising edge in a request flag, and offers one request at a time to the processor. Three 16-bit control words decide what happens to each source. A disable word blocks a source. A routing word sends an accepted source to a vectored interrupt or to an automatic transfer engine. A group word places a source in the urgent group or the ordinary group. The three words and a per-source transfer budget are written through a small write-only register bus.

A vectored offer is a valid/index pair that stays up until the processor acknowledges it. On that acknowledge the controller records that the source's group is in service and shows it on a status bit, which limits what may be offered next. A return strobe undoes the innermost level. A transfer offer is acknowledged by the transfer engine. Each transfer acknowledge counts down that source's budget. When the budget runs out, the controller sets the source back to vectored routing by itself.

Top module: `irq_accept_ctrl`

## Requirements
- R1: After reset the disable word is 0xFFFF, the routing word is 0x0000 and the group word is 0x0000. No offer is made while the disable word is all ones, even when requests arrive. `in_svc_o` and `isp_o` are 0.
- R2: A request that arrives while its source is disabled stays pending. It is offered once its disable bit is cleared. A disabled source is never offered.
- R3: A source whose routing bit is 0 is offered on `vec_valid_o`/`vec_idx_o`. A source whose routing bit is 1 is offered on `ms_req_o`/`ms_idx_o`. At most one offer is up at any time.
- R4: Among the requests that may be accepted, any urgent-group source (group bit 0) wins over every ordinary-group source (group bit 1). Inside a group, the lowest source index wins.
- R5: A request flag is set only by a 0-to-1 edge on its line, so a line held high does not request again. An offer stays up with a stable index until it is acknowledged. The acknowledge clears that source's flag.
- R6: A vectored acknowledge sets `in_svc_o`. It also copies the acknowledged source's group bit to `isp_o`. A transfer acknowledge leaves both unchanged.
- R7: While an urgent-group interrupt is in service, nothing is offered. While only an ordinary-group interrupt is in service, only urgent-group sources are offered.
- R8: `reti_i` ends the innermost level in service. After a nested urgent interrupt returns, `isp_o` reads 1 and `in_svc_o` stays 1. After the outer one returns, both read 0.
- R9: Each transfer acknowledge decrements the source's budget. When the budget is 1 or 0 at the acknowledge, the controller clears that source's routing bit, and its next request is vectored.
- R10: Register bus map on `wr_addr`: 0 is the disable word, 1 is the routing word and 2 is the group word. 16+i is the 8-bit budget of source i, taken from `wr_data[7:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 16 | Register write data |
| req_i | input | 16 | Interrupt request lines, one per source |
| vec_valid_o | output | 1 | Vectored interrupt offered |
| vec_idx_o | output | 4 | Source index of the vectored offer |
| vec_ack_i | input | 1 | Processor accepts the vectored offer |
| ms_req_o | output | 1 | Automatic transfer requested |
| ms_idx_o | output | 4 | Source index of the transfer request |
| ms_ack_i | input | 1 | Transfer engine finished one transfer |
| reti_i | input | 1 | Return from the innermost interrupt |
| in_svc_o | output | 1 | Some vectored interrupt is in service |
| isp_o | output | 1 | Group bit of the innermost interrupt in service |

## Verification
A wrong request flag shows up at the ports as a missing, repeated or out-of-order offer. This appears within a few cycles of the next acknowledge, so every drain checks the exact index sequence against an order the bench computes from the group word. Wrong in-service state shows up as an offer that should have been held back, or as a wrong `isp_o` right after an acknowledge or return. A wrong transfer budget only shows up when the routing changes. The bench therefore counts transfers to the exact boundary and then expects a vectored offer.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
  typedef enum logic [1:0] {
    OFFER_NONE = 2'd0,
    OFFER_VEC  = 2'd1,
    OFFER_XFER = 2'd2
  } offer_e;

  localparam logic [1:0] REG_DISABLE = 2'd0;
  localparam logic [1:0] REG_ROUTE   = 2'd1;
  localparam logic [1:0] REG_GROUP   = 2'd2;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_accept_pkg::*;
#(
  parameter int N  = 16,
  parameter int CW = 8,
  localparam int IW = $clog2(N),
  localparam int AW = IW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [N-1:0]  wr_data,
  input  logic          xfer_done_i,
  input  logic [IW-1:0] xfer_idx_i,
  output logic [N-1:0]  disable_o,
  output logic [N-1:0]  route_o,
  output logic [N-1:0]  group_o
);
  logic [CW-1:0] budget_mem [N];
  logic [CW-1:0] budget_rd;
  logic          budget_last;
  logic          sel_cnt;
  logic [N-1:0]  route_nxt;

  assign sel_cnt     = wr_addr[AW-1];
  assign budget_rd   = budget_mem[xfer_idx_i];
  assign budget_last = (budget_rd <= CW'(1));

  // budget storage: one write port, transfer countdown has precedence
  always_ff @(posedge clk) begin
    if (xfer_done_i)
      budget_mem[xfer_idx_i] <= (budget_rd == '0) ? '0 : budget_rd - CW'(1);
    else if (wr_en && sel_cnt)
      budget_mem[wr_addr[IW-1:0]] <= wr_data[CW-1:0];
  end

  always_comb begin
    route_nxt = route_o;
    if (wr_en && !sel_cnt && wr_addr[1:0] == REG_ROUTE)
      route_nxt = wr_data;
    if (xfer_done_i && budget_last)
      route_nxt[xfer_idx_i] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      disable_o <= '1;
      route_o   <= '0;
      group_o   <= '0;
    end else begin
      route_o <= route_nxt;
      if (wr_en && !sel_cnt && wr_addr[1:0] == REG_DISABLE) disable_o <= wr_data;
      if (wr_en && !sel_cnt && wr_addr[1:0] == REG_GROUP)   group_o   <= wr_data;
    end
  end

  // R9
  route_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_done_i && budget_last) |=> !route_o[$past(xfer_idx_i)]);
endmodule

// File: rtl/irq_pend_flags.sv
module irq_pend_flags #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req_i,
  input  logic          clr_en_i,
  input  logic [IW-1:0] clr_idx_i,
  output logic [N-1:0]  pend_o
);
  logic [N-1:0] req_prev;
  logic [N-1:0] rise;
  logic [N-1:0] clr_vec;

  assign rise = req_i & ~req_prev;

  always_comb begin
    clr_vec = '0;
    if (clr_en_i) clr_vec[clr_idx_i] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_prev <= '0;
      pend_o   <= '0;
    end else begin
      req_prev <= req_i;
      pend_o   <= (pend_o & ~clr_vec) | rise;
    end
  end

  // R5
  pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_en_i && !rise[clr_idx_i]) |=> !pend_o[$past(clr_idx_i)]);

  // R5
  level_no_retrigger_chk: assert property (@(posedge clk) disable iff (rst)
    (!pend_o[0] && req_i[0] && req_prev[0]) |=> !pend_o[0]);
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  pend_i,
  input  logic [N-1:0]  disable_i,
  input  logic [N-1:0]  group_i,
  input  logic          urg_act_i,
  input  logic          ord_act_i,
  output logic          cand_valid_o,
  output logic [IW-1:0] cand_idx_o
);
  logic [N-1:0] elig_urg;
  logic [N-1:0] elig_ord;
  logic [N-1:0] elig_sel;

  assign elig_urg = pend_i & ~disable_i & ~group_i & {N{~urg_act_i}};
  assign elig_ord = pend_i & ~disable_i &  group_i & {N{~urg_act_i & ~ord_act_i}};
  assign elig_sel = (|elig_urg) ? elig_urg : elig_ord;

  always_comb begin
    cand_valid_o = |elig_sel;
    cand_idx_o   = '0;
    for (int k = N - 1; k >= 0; k--)
      if (elig_sel[k]) cand_idx_o = IW'(k);
  end
endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import irq_accept_pkg::*;
#(
  parameter int N  = 16,
  parameter int CW = 8,
  localparam int IW = $clog2(N),
  localparam int AW = IW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [N-1:0]  wr_data,
  input  logic [N-1:0]  req_i,
  output logic          vec_valid_o,
  output logic [IW-1:0] vec_idx_o,
  input  logic          vec_ack_i,
  output logic          ms_req_o,
  output logic [IW-1:0] ms_idx_o,
  input  logic          ms_ack_i,
  input  logic          reti_i,
  output logic          in_svc_o,
  output logic          isp_o
);
  offer_e        offer_q;
  logic [IW-1:0] idx_q;
  logic          urg_act, ord_act;
  logic [N-1:0]  disable_w, route_w, group_w, pend_w;
  logic          cand_valid;
  logic [IW-1:0] cand_idx;
  logic          vec_take, xfer_take;

  assign vec_take  = (offer_q == OFFER_VEC)  && vec_ack_i;
  assign xfer_take = (offer_q == OFFER_XFER) && ms_ack_i;

  irq_cfg_regs #(.N(N), .CW(CW)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .xfer_done_i(xfer_take), .xfer_idx_i(idx_q),
    .disable_o(disable_w), .route_o(route_w), .group_o(group_w)
  );

  irq_pend_flags #(.N(N)) u_pend (
    .clk(clk), .rst(rst), .req_i(req_i),
    .clr_en_i(vec_take || xfer_take), .clr_idx_i(idx_q), .pend_o(pend_w)
  );

  irq_pick #(.N(N)) u_pick (
    .pend_i(pend_w), .disable_i(disable_w), .group_i(group_w),
    .urg_act_i(urg_act), .ord_act_i(ord_act),
    .cand_valid_o(cand_valid), .cand_idx_o(cand_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      offer_q <= OFFER_NONE;
      idx_q   <= '0;
      urg_act <= 1'b0;
      ord_act <= 1'b0;
    end else begin
      if (reti_i) begin
        if (urg_act) urg_act <= 1'b0;
        else         ord_act <= 1'b0;
      end
      case (offer_q)
        OFFER_NONE: if (cand_valid) begin
          idx_q   <= cand_idx;
          offer_q <= route_w[cand_idx] ? OFFER_XFER : OFFER_VEC;
        end
        OFFER_VEC: if (vec_ack_i) begin
          offer_q <= OFFER_NONE;
          if (group_w[idx_q]) ord_act <= 1'b1;
          else                urg_act <= 1'b1;
        end
        OFFER_XFER: if (ms_ack_i) offer_q <= OFFER_NONE;
        default: offer_q <= OFFER_NONE;
      endcase
    end
  end

  assign vec_valid_o = (offer_q == OFFER_VEC);
  assign ms_req_o    = (offer_q == OFFER_XFER);
  assign vec_idx_o   = idx_q;
  assign ms_idx_o    = idx_q;
  assign in_svc_o    = urg_act | ord_act;
  assign isp_o       = !urg_act && ord_act;

  // R2
  no_disabled_pick_chk: assert property (@(posedge clk) disable iff (rst)
    (offer_q == OFFER_NONE && cand_valid) |-> (!disable_w[cand_idx] && pend_w[cand_idx]));

  // R5
  vec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_valid_o && !vec_ack_i) |=> (vec_valid_o && $stable(vec_idx_o)));

  // R6
  isp_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_valid_o && vec_ack_i && !reti_i) |=> (in_svc_o && isp_o == $past(group_w[idx_q])));

  // R7
  urgent_block_chk: assert property (@(posedge clk) disable iff (rst)
    (urg_act && offer_q == OFFER_NONE) |=> (offer_q == OFFER_NONE));

  // R3
  one_offer_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({vec_valid_o, ms_req_o}));
endmodule

// File: tb/irq_accept_ctrl_tb.sv
module irq_accept_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] req = '0;
  logic        vec_valid, ms_req, in_svc, isp;
  logic [3:0]  vec_idx, ms_idx;
  logic        vec_ack = 1'b0, ms_ack = 1'b0, reti = 1'b0;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  irq_accept_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .req_i(req), .vec_valid_o(vec_valid), .vec_idx_o(vec_idx), .vec_ack_i(vec_ack),
    .ms_req_o(ms_req), .ms_idx_o(ms_idx), .ms_ack_i(ms_ack), .reti_i(reti),
    .in_svc_o(in_svc), .isp_o(isp)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] m);
    req = m;
    @(negedge clk);
    req = '0;
  endtask

  task automatic wait_offer();
    for (int t = 0; t < 10; t++) begin
      if (vec_valid || ms_req) break;
      @(negedge clk);
    end
  endtask

  task automatic quiet(input string tag, input int cyc);
    bit seen = 1'b0;
    for (int t = 0; t < cyc; t++) begin
      @(negedge clk);
      if (vec_valid || ms_req) seen = 1'b1;
    end
    chk(!seen, tag, seen, 0);
  endtask

  task automatic take_vec(input int exp, input string tag, input bit do_reti);
    wait_offer();
    chk(vec_valid && !ms_req && vec_idx == 4'(exp), tag, vec_valid ? int'(vec_idx) : -1, exp);
    vec_ack = 1'b1;
    @(negedge clk);
    vec_ack = 1'b0;
    if (do_reti) begin
      reti = 1'b1;
      @(negedge clk);
      reti = 1'b0;
    end
  endtask

  task automatic take_xfer(input int exp, input string tag);
    wait_offer();
    chk(ms_req && !vec_valid && ms_idx == 4'(exp), tag, ms_req ? int'(ms_idx) : -1, exp);
    ms_ack = 1'b1;
    @(negedge clk);
    ms_ack = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(!vec_valid && !ms_req, "R1 no offer after reset", vec_valid, 0);
    chk(!in_svc && !isp, "R1 status after reset", {in_svc, isp}, 0);
    req = 16'hFFFF;
    quiet("R1 all disabled at reset", 5);
    req = '0;
    // R2 pending retained; R10 address 0 is the disable word; R4 index order
    wr(0, 0);
    for (int i = 0; i < 16; i++) take_vec(i, "R2 R4 retained drain", 1'b1);
    quiet("R4 drained", 4);

    // R4 group sweep, R10 address 2
    wr(2, 16'hA5A5);
    pulse(16'hFFFF);
    for (int g = 0; g < 2; g++)
      for (int i = 0; i < 16; i++)
        if (((16'hA5A5 >> i) & 1) == g) take_vec(i, "R4 group order", 1'b1);
    quiet("R4 group drained", 4);
    wr(2, 0);

    // R2 partial disable
    wr(0, 16'hFF0F);
    pulse(16'hFFFF);
    for (int i = 4; i < 8; i++) take_vec(i, "R2 enabled subset", 1'b1);
    quiet("R2 disabled held back", 6);
    wr(0, 0);
    for (int i = 0; i < 16; i++)
      if (i < 4 || i > 7) take_vec(i, "R2 released later", 1'b1);

    // R5 level held does not retrigger
    req = 16'h0008;
    take_vec(3, "R5 first edge", 1'b1);
    quiet("R5 level no retrigger", 6);
    req = '0;
    // R5 hold until ack
    pulse(16'h0200);
    wait_offer();
    repeat (3) @(negedge clk);
    chk(vec_valid && vec_idx == 4'd9, "R5 held without ack", int'(vec_idx), 9);
    take_vec(9, "R5 ack", 1'b1);

    // R6 R7 R8 nesting: sources 2 and 7 ordinary
    wr(2, 16'h0084);
    pulse(16'h0004);
    take_vec(2, "R6 ordinary accept", 1'b0);
    chk(in_svc && isp, "R6 isp ordinary", {in_svc, isp}, 3);
    pulse(16'h0080);
    quiet("R7 ordinary blocked by ordinary", 5);
    pulse(16'h0020);
    take_vec(5, "R7 urgent nests", 1'b0);
    chk(in_svc && !isp, "R6 isp urgent", {in_svc, isp}, 2);
    pulse(16'h0002);
    quiet("R7 urgent in service blocks all", 5);
    reti = 1'b1; @(negedge clk); reti = 1'b0;
    chk(in_svc && isp, "R8 return to ordinary level", {in_svc, isp}, 3);
    take_vec(1, "R7 urgent over ordinary", 1'b1);
    chk(in_svc && isp, "R8 nested return again", {in_svc, isp}, 3);
    reti = 1'b1; @(negedge clk); reti = 1'b0;
    chk(!in_svc && !isp, "R8 outer return", {in_svc, isp}, 0);
    take_vec(7, "R7 ordinary after return", 1'b1);
    wr(2, 0);

    // R9 R10 budgets at 16+i, R3 routing word at address 1
    wr(16 + 4, 3);
    wr(16 + 6, 0);
    wr(1, 16'h0050);
    for (int k = 0; k < 3; k++) begin
      pulse(16'h0010);
      take_xfer(4, "R3 R9 transfer routed");
      chk(!in_svc, "R6 transfer leaves status", in_svc, 0);
    end
    pulse(16'h0010);
    take_vec(4, "R9 budget spent goes vectored", 1'b1);
    pulse(16'h0040);
    take_xfer(6, "R9 zero budget one transfer");
    pulse(16'h0040);
    take_vec(6, "R9 zero budget then vectored", 1'b1);
    quiet("R3 nothing left", 4);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule